// File: doc/BRIEF.md
# I2C Register Target Interface

This block is a byte-oriented I2C target that connects a small bank of 8-bit control and status registers to a two-wire bus. It takes SCL and SDA after they have been synchronised and deglitched to the system clock. It drives SDA only through an open-drain enable and has no output on SCL, so it never stretches the clock. It finds START, repeated START and STOP, matches a 7-bit address, and keeps an 8-bit register pointer.

A write frame sends the pointer first and then one or more data bytes. Each data byte is committed on the register-file port during the high phase of its acknowledge clock. With `pair_mode_i` low, the data bytes that follow land on consecutive addresses. With `pair_mode_i` high, the bytes that follow alternate between a new pointer and its data. A read frame returns the byte at the pointer, most significant bit first. Each master ACK moves the pointer on and starts the next byte. A one-cycle `read_start_o` pulse marks every byte loaded for sending, so that clear-on-read registers can react to it.

Top module: `i2c_reg_target`

## Requirements
- R1: While reset is asserted, and right after it, SDA is released (`sda_oe_o`=0), and `reg_we_o` and `read_start_o` are low.
- R2: On the ninth clock of an address byte, the block acknowledges only when bits 7:1 equal the parameter DEV_ADDR (default 0x42). Bit 0 is R/nW: 0 for a write, 1 for a read.
- R3: The general call address (first byte 0x00) is never acknowledged.
- R4: In a write, the byte after the address is the pointer and the next byte is data. That data is presented on `reg_wdata_o` at `reg_addr_o`=pointer, with `reg_we_o` high for exactly one clock while SCL is high during its acknowledge bit.
- R5: With `pair_mode_i`=0, each further data byte in the same frame is written to the pointer plus one, plus two, and so on.
- R6: With `pair_mode_i`=1, the bytes after each committed data byte alternate between a new pointer and the data for that pointer. No other register is touched.
- R7: A read returns the byte at the pointer, MSB first. A master ACK (SDA low on the ninth clock) advances the pointer and starts the next byte. A master NACK ends the transfer, and SDA stays released until the next START.
- R8: `read_start_o` pulses for one clock, with SCL low, once for every byte loaded for sending. It is never high in the same cycle as `reg_we_o`.
- R9: A START or repeated START at any point, including in the middle of a byte, restarts the address phase. After a STOP or an address mismatch, no byte is acknowledged or written until the next START.
- R10: The SDA drive enable changes only while SCL is low. It never changes across an SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low bus reset; returns the block to idle |
| scl_i | input | 1 | Synchronised, deglitched SCL |
| sda_i | input | 1 | Synchronised, deglitched SDA (bus level) |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| pair_mode_i | input | 1 | 0: auto-increment writes, 1: pointer/data pairs |
| reg_addr_o | output | 8 | Register-file address (current pointer) |
| reg_we_o | output | 1 | One-clock write strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rdata_i | input | 8 | Read data for `reg_addr_o` |
| read_start_o | output | 1 | One-clock pulse when a byte is loaded for sending |

## Verification
Two events can meet in the same SCL phase: a repeated START can arrive in the middle of a byte, while the bit counter and shift register still hold a partial address. The START has to win. It must clear the partial byte, leave SDA released, and let the following frame decode cleanly. The bench provokes this by clocking three address bits and then issuing a repeated START. It then runs a full write, and judges the result by reading the register file for the written value.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_RDATA
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SDA edges only count as conditions when SCL is steady high
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_byte_shift.sv
module i2c_byte_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rx_en_i,
  input  logic         rx_bit_i,
  input  logic         tx_load_i,
  input  logic [W-1:0] tx_data_i,
  input  logic         tx_shift_i,
  output logic [W-1:0] rx_byte_o,
  output logic         tx_bit_o
);
  logic [W-1:0] rx_q, tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q <= '0;
      tx_q <= '1;
    end else begin
      if (rx_en_i)        rx_q <= {rx_q[W-2:0], rx_bit_i};
      if (tx_load_i)      tx_q <= tx_data_i;
      else if (tx_shift_i) tx_q <= {tx_q[W-2:0], 1'b1};
    end
  end

  assign rx_byte_o = rx_q;
  assign tx_bit_o  = tx_q[W-1];
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h42
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              pair_mode_i,
  output logic [BYTE_W-1:0] reg_addr_o,
  output logic              reg_we_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  output logic              read_start_o
);
  localparam logic [6:0]       GCALL    = 7'h00;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic scl_rise, scl_fall, bus_start, bus_stop;
  tgt_state_e state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic              ack_q, done_q, drv_ack_q, rd_q, we_q, rs_q;
  logic [BYTE_W-1:0] ptr_q, rx_byte;
  logic              tx_bit, rx_en, tx_load, tx_shift, active, addr_hit;

  i2c_line_events u_ev (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (bus_start),
    .stop_o    (bus_stop)
  );

  assign active   = (state_q != ST_IDLE);
  assign rx_en    = active & scl_rise & ~ack_q;
  assign tx_shift = (state_q == ST_RDATA) & scl_fall & ~ack_q & ~done_q;
  // next byte leaves on the falling edge that closes an acknowledge
  assign tx_load  = scl_fall & ack_q & ~done_q &
                    (((state_q == ST_ADDR) & rd_q) | (state_q == ST_RDATA));
  assign addr_hit = (rx_byte[7:1] == DEV_ADDR) && (rx_byte[7:1] != GCALL);

  i2c_byte_shift #(.W(BYTE_W)) u_sh (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_en_i   (rx_en),
    .rx_bit_i  (sda_i),
    .tx_load_i (tx_load),
    .tx_data_i (reg_rdata_i),
    .tx_shift_i(tx_shift),
    .rx_byte_o (rx_byte),
    .tx_bit_o  (tx_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      ack_q     <= 1'b0;
      done_q    <= 1'b0;
      drv_ack_q <= 1'b0;
      rd_q      <= 1'b0;
      ptr_q     <= '0;
      we_q      <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      we_q <= 1'b0;
      rs_q <= tx_load;
      if (bus_start) begin
        state_q   <= ST_ADDR;
        bit_cnt_q <= '0;
        ack_q     <= 1'b0;
        done_q    <= 1'b0;
        drv_ack_q <= 1'b0;
      end else if (bus_stop) begin
        state_q   <= ST_IDLE;
        ack_q     <= 1'b0;
        done_q    <= 1'b0;
        drv_ack_q <= 1'b0;
      end else if (active) begin
        if (scl_rise) begin
          if (!ack_q) begin
            if (bit_cnt_q == LAST_BIT) done_q <= 1'b1;
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (state_q == ST_WDATA) begin
            we_q <= 1'b1;
          end else if (state_q == ST_RDATA) begin
            if (sda_i) begin
              state_q <= ST_IDLE;
              ack_q   <= 1'b0;
            end else begin
              ptr_q <= ptr_q + 1'b1;
            end
          end
        end else if (scl_fall) begin
          if (done_q) begin
            done_q <= 1'b0;
            unique case (state_q)
              ST_ADDR: begin
                if (addr_hit) begin
                  ack_q     <= 1'b1;
                  drv_ack_q <= 1'b1;
                  rd_q      <= rx_byte[0];
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              ST_PTR: begin
                ptr_q     <= rx_byte;
                ack_q     <= 1'b1;
                drv_ack_q <= 1'b1;
              end
              ST_WDATA: begin
                ack_q     <= 1'b1;
                drv_ack_q <= 1'b1;
              end
              default: ack_q <= 1'b1;  // read: master owns the ninth bit
            endcase
          end else if (ack_q) begin
            ack_q     <= 1'b0;
            drv_ack_q <= 1'b0;
            unique case (state_q)
              ST_ADDR:  state_q <= rd_q ? ST_RDATA : ST_PTR;
              ST_PTR:   state_q <= ST_WDATA;
              ST_WDATA: begin
                if (pair_mode_i) state_q <= ST_PTR;
                else             ptr_q   <= ptr_q + 1'b1;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  assign sda_oe_o     = drv_ack_q | ((state_q == ST_RDATA) & ~ack_q & ~tx_bit);
  assign reg_addr_o   = ptr_q;
  assign reg_we_o     = we_q;
  assign reg_wdata_o  = rx_byte;
  assign read_start_o = rs_q;
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_i,
  input logic sda_oe_o,
  input logic reg_we_o,
  input logic read_start_o
);
  assert_oe_steady_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));

  assert_we_in_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> scl_i);

  assert_we_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  assert_rs_in_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_start_o |-> !scl_i);

  assert_rs_we_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && read_start_o));

  assert_start_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i) && $past(sda_i) && !sda_i) |=> !sda_oe_o);
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_i       (scl_i),
  .sda_i       (sda_i),
  .sda_oe_o    (sda_oe_o),
  .reg_we_o    (reg_we_o),
  .read_start_o(read_start_o)
);

// File: tb/sim_i2c_reg_target.sv
`timescale 1ns/1ps
module sim_i2c_reg_target;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic pair_mode = 1'b0;
  logic sda_bus, sda_oe, we, rs;
  logic [7:0] addr, wdata, rdata;
  logic [7:0] regs [16];

  int checks = 0, errors = 0;
  int we_cnt = 0, rs_cnt = 0, we_bad = 0, oe_bad = 0;
  bit finished = 1'b0;
  logic scl_prev = 1'b1, oe_prev = 1'b0;

  always #4 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;
  assign rdata   = regs[addr[3:0]];

  i2c_reg_target u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .pair_mode_i (pair_mode),
    .reg_addr_o  (addr),
    .reg_we_o    (we),
    .reg_wdata_o (wdata),
    .reg_rdata_i (rdata),
    .read_start_o(rs)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) regs[i] <= 8'h00;
    end else if (we) begin
      regs[addr[3:0]] <= wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (we) begin
        we_cnt++;
        if (!scl) we_bad++;
      end
      if (rs) rs_cnt++;
      if (scl && scl_prev && (sda_oe != oe_prev)) oe_bad++;
    end
    scl_prev = scl;
    oe_prev  = sda_oe;
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; w(Q);
    scl = 1'b1; w(Q);
    m_sda = 1'b0; w(Q);
    scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; w(Q);
    scl = 1'b1; w(Q);
    m_sda = 1'b1; w(Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; w(Q);
    scl = 1'b1; w(Q);
    scl = 1'b0; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; w(Q);
    scl = 1'b1; w(2);
    acked = ~sda_bus;
    w(Q - 2);
    scl = 1'b0; w(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      w(Q);
      scl = 1'b1; w(Q);
      b = {b[6:0], sda_bus};
      scl = 1'b0;
    end
    w(Q);
    m_sda = give_ack ? 1'b0 : 1'b1; w(Q);
    scl = 1'b1; w(Q);
    scl = 1'b0; w(Q);
    m_sda = 1'b1;
  endtask

  task automatic t_reset();
    check("R1 sda_oe in reset", sda_oe, 0);
    rst_n = 1'b1; w(3);
    check("R1 sda_oe after reset", sda_oe, 0);
    check("R1 strobes idle", {we, rs}, 0);
  endtask

  task automatic t_gencall();
    logic a;
    bus_start();
    send_byte(8'h00, a);
    check("R3 general call ack", a, 0);
    send_byte(8'h05, a);
    check("R9 byte after general call ack", a, 0);
    bus_stop();
  endtask

  task automatic t_mismatch();
    logic a;
    int w0 = we_cnt;
    bus_start();
    send_byte(8'h44, a);
    check("R2 wrong address ack", a, 0);
    send_byte(8'h03, a);
    check("R9 pointer after mismatch ack", a, 0);
    send_byte(8'h99, a);
    bus_stop();
    check("R9 writes after mismatch", we_cnt - w0, 0);
  endtask

  task automatic t_single_write();
    logic a;
    int w0 = we_cnt;
    bus_start();
    send_byte(8'h84, a);
    check("R2 matching address ack", a, 1);
    send_byte(8'h02, a);
    send_byte(8'hA5, a);
    bus_stop();
    check("R4 register 2 value", regs[2], 8'hA5);
    check("R4 single strobe", we_cnt - w0, 1);
  endtask

  task automatic t_seq_write();
    logic a;
    pair_mode = 1'b0;
    bus_start();
    send_byte(8'h84, a);
    send_byte(8'h04, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    send_byte(8'h33, a);
    bus_stop();
    check("R5 reg4", regs[4], 8'h11);
    check("R5 reg5", regs[5], 8'h22);
    check("R5 reg6", regs[6], 8'h33);
  endtask

  task automatic t_pair_write();
    logic a;
    pair_mode = 1'b1;
    bus_start();
    send_byte(8'h84, a);
    send_byte(8'h08, a);
    send_byte(8'h5A, a);
    send_byte(8'h0C, a);
    send_byte(8'hC3, a);
    bus_stop();
    pair_mode = 1'b0;
    check("R6 reg8", regs[8], 8'h5A);
    check("R6 reg12", regs[12], 8'hC3);
    check("R6 reg9 untouched", regs[9], 8'h00);
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] d;
    int r0 = rs_cnt;
    bus_start();
    send_byte(8'h84, a);
    send_byte(8'h04, a);
    bus_start();
    send_byte(8'h85, a);
    check("R2 read address ack", a, 1);
    recv_byte(1'b1, d); check("R7 read byte 0", d, 8'h11);
    recv_byte(1'b1, d); check("R7 read byte 1", d, 8'h22);
    recv_byte(1'b0, d); check("R7 read byte 2", d, 8'h33);
    check("R8 read_start count", rs_cnt - r0, 3);
    recv_byte(1'b0, d);
    check("R7 bus released after NACK", d, 8'hFF);
    bus_stop();
  endtask

  task automatic t_abort();
    logic a;
    bus_start();
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b0);
    bus_start();
    send_byte(8'h84, a);
    send_byte(8'h0A, a);
    send_byte(8'h77, a);
    bus_stop();
    check("R9 write after mid-byte restart", regs[10], 8'h77);
  endtask

  task automatic t_stop_ignore();
    logic a;
    send_byte(8'h84, a);
    check("R9 no ack after STOP without START", a, 0);
  endtask

  initial begin
    w(4);
    t_reset();
    t_gencall();
    t_mismatch();
    t_single_write();
    t_seq_write();
    t_pair_write();
    t_read();
    t_abort();
    t_stop_ignore();
    check("R4 strobe outside SCL high", we_bad, 0);
    check("R10 SDA drive change in SCL high", oe_bad, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule